// File: doc/BRIEF.md
# Field-Locked Pixel Tick Generator

The block produces pixel-rate timing for a video path from a fixed reference clock. Everything runs in the reference clock domain. A phase accumulator adds a programmed step word to itself on every reference cycle, and each carry out of its top bit marks one pixel tick. Two power-of-two dividers follow the accumulator. One produces a clock enable for an outgoing pixel clock. The other produces a clock enable for internal pixel logic. Both outputs are single-cycle enables, not generated clocks, so restarting a divider cannot produce a runt pulse.

The block is locked to the video field. A V-sync strobe marks the start of each field. At that point:
- the step word is adopted;
- both divider counters restart;
- if clearing is enabled, the accumulator phase is zeroed.

With clearing enabled, pixel timing becomes an exact multiple of the field rate.

The internal logic can instead be run directly from an outside pixel clock. When that source is selected, a bypass indicator tells the input buffer to step aside, and the internal enable is muted. Selecting divide-by-8 for the internal divider is not allowed. Such a request raises an error flag, and the previous legal ratio is kept.

Top module: `pclk_fieldlock_gen`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released with idle inputs, all four outputs are low.
- R2: Every carry out of the ACC_W-bit accumulator (accumulator plus step reaching 2^ACC_W) gives one pixel tick. With divide-by-1 selected, the external enable is high in the second cycle after the cycle in which the carry occurs.
- R3: A new step word on the step input takes effect only in a cycle where the V-sync strobe is high. Changes at other times do not alter the tick rate.
- R4: When the clear enable is high during V-sync, the accumulator restarts from zero. With a step of 2^ACC_W/4, the first external enable at divide-by-1 is then seen on the sixth falling edge counted from the V-sync edge.
- R5: Ratio codes are 2 bits: 00 is divide by 1, 01 by 2, 10 by 4, 11 by 8. The external divider honours all four codes and raises its enable on one tick out of every 2^code ticks.
- R6: When the internal ratio code is 11, the error flag is high from the next cycle on. The internal divider keeps its previous legal ratio. A legal code clears the flag on the next cycle.
- R7: A V-sync cycle restarts both divider counts at zero and suppresses any enable in the following cycle.
- R8: Selecting the outside pixel clock source raises the bypass indicator one cycle later, and the internal enable stays low while the indicator is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_i | input | ACC_W | Accumulator step word, adopted at V-sync |
| ext_code_i | input | 2 | External divider ratio code |
| int_code_i | input | 2 | Internal divider ratio code |
| vsync_i | input | 1 | Field start strobe |
| clr_on_vs_i | input | 1 | Zero the accumulator phase at V-sync |
| src_pix_i | input | 1 | Run internal logic from outside pixel clock |
| ext_en_o | output | 1 | External pixel clock enable |
| int_en_o | output | 1 | Internal pixel clock enable |
| fifo_bypass_o | output | 1 | Input buffer bypass indicator |
| cfg_err_o | output | 1 | Illegal internal ratio requested |

## Verification
The bench builds the block with ACC_W set to 10 instead of 24. A step of 256 then gives a tick every fourth cycle, and a step of 512 gives one every second cycle. Carries, divider wrap-around, restarts that land mid-count and the accumulator-clear timing therefore all occur within a few hundred cycles. The divider width follows from the 2-bit code, so every ratio, including the forbidden one, is reached at default settings.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  localparam int unsigned CODE_W = 2;
  localparam int unsigned CNT_W  = (1 << CODE_W) - 1;

  typedef enum logic [CODE_W-1:0] {
    RATIO_1 = 2'b00,
    RATIO_2 = 2'b01,
    RATIO_4 = 2'b10,
    RATIO_8 = 2'b11
  } ratio_e;
endpackage

// File: rtl/pclk_rst_sync.sv
module pclk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/pclk_dto.sv
module pclk_dto #(
  parameter int unsigned ACC_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] step_i,
  input  logic             field_i,
  input  logic             clr_en_i,
  output logic             tick_o
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W-1:0] step_q, step_d;
  logic             tick_q, tick_d;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum    = {1'b0, acc_q} + {1'b0, step_q};
    step_d = field_i ? step_i : step_q;
    if (field_i && clr_en_i) begin
      acc_d  = '0;
      tick_d = 1'b0;
    end else begin
      acc_d  = sum[ACC_W-1:0];
      tick_d = sum[ACC_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      step_q <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      step_q <= step_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  a_r3_step_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !field_i |=> $stable(step_q));
  a_r4_phase_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_i && clr_en_i) |=> (acc_q == '0 && !tick_o));
endmodule

// File: rtl/pclk_div.sv
module pclk_div
  import pclk_pkg::*;
#(
  parameter bit ALLOW_TOP = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              restart_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              en_o,
  output logic              bad_o
);
  logic              legal;
  logic [CODE_W-1:0] ratio_q, ratio_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  mask;
  logic              en_q, en_d;
  logic              bad_q, bad_d;

  generate
    if (ALLOW_TOP) begin : g_all_legal
      assign legal = 1'b1;
    end else begin : g_top_banned
      assign legal = (code_i != RATIO_8);
    end
  endgenerate

  assign mask = ~({CNT_W{1'b1}} << ratio_q);

  always_comb begin
    ratio_d = legal ? code_i : ratio_q;
    bad_d   = !legal;
    cnt_d   = cnt_q;
    en_d    = 1'b0;
    if (restart_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      en_d  = ((cnt_q & mask) == mask);
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= RATIO_1;
      cnt_q   <= '0;
      en_q    <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      ratio_q <= ratio_d;
      cnt_q   <= cnt_d;
      en_q    <= en_d;
      bad_q   <= bad_d;
    end
  end

  assign en_o  = en_q;
  assign bad_o = bad_q;

  a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0 && !en_o));
  a_r6_ratio_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legal |=> $stable(ratio_q));
  a_r6_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legal |=> bad_o);
  a_r2_en_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |-> $past(tick_i));
endmodule

// File: rtl/pclk_fieldlock_gen.sv
module pclk_fieldlock_gen
  import pclk_pkg::*;
#(
  parameter int unsigned ACC_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] step_i,
  input  logic [1:0]       ext_code_i,
  input  logic [1:0]       int_code_i,
  input  logic             vsync_i,
  input  logic             clr_on_vs_i,
  input  logic             src_pix_i,
  output logic             ext_en_o,
  output logic             int_en_o,
  output logic             fifo_bypass_o,
  output logic             cfg_err_o
);
  localparam int unsigned NDIV = 2;

  logic                    rst_n;
  logic                    tick;
  logic [CODE_W-1:0]       code  [NDIV];
  logic [NDIV-1:0]         en;
  logic [NDIV-1:0]         bad;
  logic                    byp_q, byp_d;

  pclk_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n)
  );

  pclk_dto #(.ACC_W(ACC_W)) u_dto (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .step_i  (step_i),
    .field_i (vsync_i),
    .clr_en_i(clr_on_vs_i),
    .tick_o  (tick)
  );

  assign code[0] = ext_code_i;
  assign code[1] = int_code_i;

  generate
    for (genvar g = 0; g < NDIV; g++) begin : g_div
      pclk_div #(.ALLOW_TOP(g == 0)) u_div (
        .clk_i    (clk_i),
        .rst_ni   (rst_n),
        .tick_i   (tick),
        .restart_i(vsync_i),
        .code_i   (code[g]),
        .en_o     (en[g]),
        .bad_o    (bad[g])
      );
    end
  endgenerate

  always_comb byp_d = src_pix_i;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) byp_q <= 1'b0;
    else        byp_q <= byp_d;
  end

  assign ext_en_o      = en[0];
  assign int_en_o      = en[1] & ~byp_q;
  assign fifo_bypass_o = byp_q;
  assign cfg_err_o     = bad[1];

  a_r8_bypass_follow: assert property (@(posedge clk_i) disable iff (!rst_n)
    src_pix_i |=> fifo_bypass_o);
  a_r6_ext_never_flags: assert property (@(posedge clk_i) disable iff (!rst_n)
    !bad[0]);
endmodule

// File: tb/tb_pclk_fieldlock_gen.sv
module tb_pclk_fieldlock_gen;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int FULL = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] step = '0;
  logic [1:0]    ext_code = 2'b00;
  logic [1:0]    int_code = 2'b00;
  logic          vs = 1'b0;
  logic          clr = 1'b0;
  logic          src = 1'b0;
  logic          ext_en, int_en, byp, err;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  pclk_fieldlock_gen #(.ACC_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step),
    .ext_code_i(ext_code), .int_code_i(int_code),
    .vsync_i(vs), .clr_on_vs_i(clr), .src_pix_i(src),
    .ext_en_o(ext_en), .int_en_o(int_en),
    .fifo_bypass_o(byp), .cfg_err_o(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_acc, m_step, m_tick, m_byp, m_bad;
  int m_ratio [2];
  int m_cnt [2];
  int m_en [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_step = 0; m_tick = 0; m_byp = 0; m_bad = 0;
      for (int d = 0; d < 2; d++) begin
        m_ratio[d] = 0; m_cnt[d] = 0; m_en[d] = 0;
      end
    end else begin
      int sum, nt, c, msk;
      sum = m_acc + m_step;
      if (vs && clr) begin m_acc = 0; nt = 0; end
      else begin m_acc = sum % FULL; nt = (sum >= FULL); end
      if (vs) m_step = int'(step);
      for (int d = 0; d < 2; d++) begin
        msk = (1 << m_ratio[d]) - 1;
        if (vs) begin m_cnt[d] = 0; m_en[d] = 0; end
        else if (m_tick != 0) begin
          m_en[d] = ((m_cnt[d] & msk) == msk);
          m_cnt[d] = (m_cnt[d] + 1) % 8;
        end else m_en[d] = 0;
        c = (d == 0) ? int'(ext_code) : int'(int_code);
        if (d == 0 || c != 3) m_ratio[d] = c;
      end
      m_bad = (int_code == 2'b11);
      m_tick = nt;
      m_byp = src;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  int cnt_ext = 0, cnt_int = 0;
  always @(negedge clk) begin
    cycles++;
    chk(ext_en == m_en[0], "R5 ext_en vs model", ext_en, m_en[0]);
    chk(int_en == (m_en[1] && !m_byp), "R6/R8 int_en vs model", int_en, m_en[1] && !m_byp);
    chk(byp == m_byp, "R8 bypass vs model", byp, m_byp);
    chk(err == m_bad, "R6 flag vs model", err, m_bad);
    cnt_ext += ext_en;
    cnt_int += int_en;
  end

  task automatic pulse_vs();
    @(posedge clk); #1 vs = 1'b1;
    @(posedge clk); #1 vs = 1'b0;
  endtask

  task automatic window(input int n, output int e, output int i);
    @(posedge clk); #2;
    cnt_ext = 0; cnt_int = 0;
    repeat (n) @(posedge clk);
    #2 e = cnt_ext; i = cnt_int;
  endtask

  initial begin
    int e, i, k;
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    chk(!ext_en && !int_en && !byp && !err, "R1 reset", {ext_en, int_en, byp, err}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!ext_en && !int_en && !byp && !err, "R1 after release", {ext_en, int_en, byp, err}, 0);

    // R4: phase clear, step of a quarter range
    step = AW'(FULL / 4); clr = 1'b1;
    @(posedge clk); #1 vs = 1'b1;
    @(posedge clk); #1 vs = 1'b0;
    k = 0;
    for (int n = 1; n <= 10 && k == 0; n++) begin
      @(negedge clk); #1;
      if (ext_en) k = n;
    end
    chk(k == 6, "R4 first enable after clear", k, 6);

    // R2: divide-by-1 tick rate
    window(400, e, i);
    chk(e >= 99 && e <= 101, "R2 ext rate /1", e, 100);
    chk(i >= 99 && i <= 101, "R2 int rate /1", i, 100);

    // R3: step change without V-sync ignored
    #1 step = AW'(FULL / 2);
    window(400, e, i);
    chk(e >= 99 && e <= 101, "R3 step ignored mid-field", e, 100);
    pulse_vs();
    window(400, e, i);
    chk(e >= 199 && e <= 201, "R3 step adopted at V-sync", e, 200);

    // R5: external ratios
    for (int c = 1; c < 4; c++) begin
      #1 ext_code = 2'(c);
      pulse_vs();
      window(400, e, i);
      chk(e >= (200 >> c) - 1 && e <= (200 >> c) + 1, "R5 ext ratio", e, 200 >> c);
    end

    // R6: forbidden internal ratio keeps /2
    #1 int_code = 2'b01;
    pulse_vs();
    #1 int_code = 2'b11;
    @(negedge clk); @(negedge clk);
    chk(err == 1'b1, "R6 flag raised", err, 1);
    window(400, e, i);
    chk(i >= 99 && i <= 101, "R6 ratio held at /2", i, 100);
    #1 int_code = 2'b10;
    @(negedge clk); @(negedge clk);
    chk(err == 1'b0, "R6 flag cleared", err, 0);

    // R7: restart mid-count, no clear, odd step
    clr = 1'b0; step = AW'(300);
    for (int r = 0; r < 5; r++) begin
      repeat (7 + r) @(posedge clk);
      pulse_vs();
      @(negedge clk);
      chk(!ext_en && !int_en, "R7 no enable after restart", ext_en | int_en, 0);
    end

    // R8: bypass mutes internal enable
    #1 src = 1'b1; int_code = 2'b00;
    @(negedge clk); @(negedge clk);
    chk(byp == 1'b1, "R8 bypass raised", byp, 1);
    window(200, e, i);
    chk(i == 0, "R8 internal muted", i, 0);
    chk(e > 0, "R8 external still runs", e, 1);
    #1 src = 1'b0;
    repeat (20) @(posedge clk);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule